// File: doc/BRIEF.md
# SPI Controller Status and Error Flag Unit

This block holds the mode and error state of a serial peripheral controller. Eight flags live in it: the operating-mode flag (0 = configuration, 1 = active), the host-role flag, and six error flags covering mode fault, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Together with a busy indication from the shifter, the flags are presented as one read-only status word.

Software changes flags only through a write-only command word. Each flag has its own write-one-to-set bit and its own write-one-to-clear bit in that word, so a single write can change any subset of flags without a read-modify-write sequence. Event pulses from the shifter and the FIFOs raise the error flags directly. Five of those events are qualified by per-error enables taken from the controller's control word. The mode-fault event has no enable.

A registered, level-sensitive error interrupt is raised while any error flag is set and the error interrupt enable is high.

Top module: `ssc_status_flags`

## Requirements
- R1: While `rst` is high at a clock edge, all flags, the busy bit and `err_irq` go to 0, whatever the other inputs are.
- R2: `stat_o` bit positions are fixed: mode flag 0, host-role flag 1, mode fault 7, TX overflow 8, RX overflow 9, abort 10, TX underflow 11, RX underflow 12, busy 13. All other bits read 0.
- R3: A command write with one set bit raises its flag at the next clock edge. The set bit positions are: mode 1, host role 3, RX underflow 5, mode fault 7, TX overflow 12, RX overflow 13, abort 14, TX underflow 15.
- R4: A command write with one clear bit drops its flag at the next clock edge. The clear bit positions are: mode 0, host role 2, RX underflow 4, mode fault 6, TX overflow 8, RX overflow 9, abort 10, TX underflow 11.
- R5: If the set bit and the clear bit of the same flag are written together, the flag ends cleared.
- R6: The `hw_evt` bits are: 0 mode fault, 1 TX overflow, 2 RX overflow, 3 abort, 4 TX underflow, 5 RX underflow. An event sets its flag at the next edge. For bits 1 to 5 this happens only when the matching enable is 1. The enables in `err_en` are: 0 TX overflow, 1 RX overflow, 2 abort, 3 TX underflow, 4 RX underflow, which are control word bits 8 to 12. The mode-fault event is never gated.
- R7: A hardware event in the same cycle as a software clear of that flag leaves the flag set.
- R8: With `cmd_wr` low, `cmd_data` has no effect. A command write of all zeros changes no flag.
- R9: `err_irq` is registered. After each edge it equals `err_irq_en` AND (any error flag set), both taken as they were just before that edge.
- R10: The busy bit takes the value of `shift_busy` at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | CMD_W (16) | Command word: set and clear bits |
| hw_evt | input | 6 | Error event pulses from shifter and FIFOs |
| err_en | input | 5 | Per-error capture enables (control word bits 12:8) |
| err_irq_en | input | 1 | Error interrupt enable |
| shift_busy | input | 1 | Shifter busy indication |
| stat_o | output | STAT_W (16) | Status word |
| err_irq | output | 1 | Level error interrupt |

## Verification
A flag cell that keeps the wrong value shows up in `stat_o` one edge after the write or event that should have changed it. That flag then stays wrong until a later command overrides it. A wrong priority between set, clear and event appears only in cycles where two of them coincide, so the stimulus drives them together on purpose. A fault in the interrupt path appears on `err_irq` one edge after the status word, because the interrupt is registered from the flag state.

// File: rtl/ssc_flag_pkg.sv
package ssc_flag_pkg;
  localparam int NFLAG    = 8;
  localparam int NERR     = 6;
  localparam int NGATED   = NERR - 1;
  localparam int BUSY_POS = 13;

  // flag index: 0 mode, 1 host role, 2 mode fault, 3 tx ovf, 4 rx ovf,
  // 5 abort, 6 tx udf, 7 rx udf
  function automatic int stat_pos(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 7;
      default: return k + 5;
    endcase
  endfunction

  function automatic int set_pos(input int k);
    case (k)
      0: return 1;
      1: return 3;
      2: return 7;
      7: return 5;
      default: return k + 9;
    endcase
  endfunction

  function automatic int clr_pos(input int k);
    case (k)
      0: return 0;
      1: return 2;
      2: return 6;
      7: return 4;
      default: return k + 5;
    endcase
  endfunction
endpackage

// File: rtl/ssc_cmd_decode.sv
module ssc_cmd_decode
  import ssc_flag_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic             wr_i,
  input  logic [CMD_W-1:0] data_i,
  output logic [NFLAG-1:0] set_o,
  output logic [NFLAG-1:0] clr_o
);
  for (genvar k = 0; k < NFLAG; k++) begin : g_dec
    localparam int SP = set_pos(k);
    localparam int CP = clr_pos(k);
    assign set_o[k] = wr_i & data_i[SP];
    assign clr_o[k] = wr_i & data_i[CP];
  end
endmodule

// File: rtl/ssc_flag_cell.sv
module ssc_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic hw_i,
  output logic q_o
);
  // priority: hardware event > software clear > software set > hold
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (hw_i)  q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !hw_i) |=> !q_o);
  p_hw_over_clear_r7: assert property (@(posedge clk) disable iff (rst)
    hw_i |=> q_o);
  p_set_takes_r3: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> q_o);
  p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i && !hw_i) |=> $stable(q_o));
endmodule

// File: rtl/ssc_status_flags.sv
module ssc_status_flags
  import ssc_flag_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [NERR-1:0]   hw_evt,
  input  logic [NGATED-1:0] err_en,
  input  logic              err_irq_en,
  input  logic              shift_busy,
  output logic [STAT_W-1:0] stat_o,
  output logic              err_irq
);
  localparam int FIRST_ERR = NFLAG - NERR;

  logic [NFLAG-1:0] set_v, clr_v, hw_v, flag_q;
  logic [NERR-1:0]  err_q;
  logic             busy_q;

  ssc_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .wr_i(cmd_wr), .data_i(cmd_data), .set_o(set_v), .clr_o(clr_v)
  );

  // event qualification: mode fault ungated, other errors gated
  assign hw_v[FIRST_ERR-1:0] = '0;
  assign hw_v[FIRST_ERR]     = hw_evt[0];
  for (genvar j = 1; j < NERR; j++) begin : g_gate
    assign hw_v[FIRST_ERR+j] = hw_evt[j] & err_en[j-1];
  end

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    ssc_flag_cell u_cell (
      .clk(clk), .rst(rst), .set_i(set_v[k]), .clr_i(clr_v[k]),
      .hw_i(hw_v[k]), .q_o(flag_q[k])
    );
  end

  assign err_q = flag_q[NFLAG-1:FIRST_ERR];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      busy_q  <= shift_busy;
      err_irq <= err_irq_en & (|err_q);
    end
  end

  always_comb begin
    stat_o = '0;
    for (int k = 0; k < NFLAG; k++) stat_o[stat_pos(k)] = flag_q[k];
    stat_o[BUSY_POS] = busy_q;
  end

  for (genvar j = 1; j < NERR; j++) begin : g_chk_gate
    p_gated_r6: assert property (@(posedge clk) disable iff (rst)
      (!err_en[j-1] && !set_v[FIRST_ERR+j] && !stat_o[stat_pos(FIRST_ERR+j)])
        |=> !stat_o[stat_pos(FIRST_ERR+j)]);
  end

  p_irq_on_r9: assert property (@(posedge clk) disable iff (rst)
    (err_irq_en && (|stat_o[12:7])) |=> err_irq);
  p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!err_irq_en || !(|stat_o[12:7])) |=> !err_irq);
  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    shift_busy |=> stat_o[BUSY_POS]);
  p_zero_bits_r2: assert property (@(posedge clk) disable iff (rst)
    stat_o[6:2] == 5'd0);
endmodule

// File: tb/tb_ssc_status_flags.sv
`timescale 1ns/1ps
module tb_ssc_status_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_data = '0;
  logic [5:0]  hw_evt = '0;
  logic [4:0]  err_en = '0;
  logic        err_irq_en = 1'b0;
  logic        shift_busy = 1'b0;
  logic [15:0] stat_o;
  logic        err_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ssc_status_flags dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .hw_evt(hw_evt), .err_en(err_en), .err_irq_en(err_irq_en),
    .shift_busy(shift_busy), .stat_o(stat_o), .err_irq(err_irq)
  );

  // bench view of the bit layouts, flag order:
  // mode, host, mode fault, txovf, rxovf, abort, txudf, rxudf
  int sp[8] = '{0, 1, 7, 8, 9, 10, 11, 12};
  int setp[8] = '{1, 3, 7, 12, 13, 14, 15, 5};
  int clrp[8] = '{0, 2, 6, 8, 9, 10, 11, 4};

  logic [15:0] m_st = '0;
  logic [15:0] q_st[$];
  logic        q_irq[$];
  string       q_tag[$];

  task automatic step(input logic wr, input logic [15:0] d, input logic [5:0] ev,
                      input logic [4:0] en, input logic ie, input logic bz,
                      input string tag);
    logic [15:0] nx;
    logic s, c, h;
    @(negedge clk);
    cmd_wr = wr; cmd_data = d; hw_evt = ev; err_en = en;
    err_irq_en = ie; shift_busy = bz;
    nx = '0;
    for (int k = 0; k < 8; k++) begin
      s = wr & d[setp[k]];
      c = wr & d[clrp[k]];
      if (k < 2)       h = 1'b0;
      else if (k == 2) h = ev[0];
      else             h = ev[k-2] & en[k-3];
      nx[sp[k]] = h | (~c & (s | m_st[sp[k]]));
    end
    nx[13] = bz;
    q_irq.push_back(ie & (|m_st[12:7]));
    q_st.push_back(nx);
    q_tag.push_back(tag);
    m_st = nx;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0, 6'h0, 5'h1f, err_irq_en, 1'b0, tag);
  endtask

  // monitor: compares each result against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_st.size() > 0) begin
        logic [15:0] es;
        logic ei;
        string t;
        es = q_st.pop_front();
        ei = q_irq.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (stat_o !== es) begin
          fails++;
          $display("FAIL %s status actual=%h expected=%h", t, stat_o, es);
        end
        checks++;
        if (err_irq !== ei) begin
          fails++;
          $display("FAIL %s R9 irq actual=%b expected=%b", t, err_irq, ei);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    // R1: reset dominates every active input
    cmd_wr = 1'b1; cmd_data = 16'hAAAA; hw_evt = 6'h3f; err_en = 5'h1f;
    err_irq_en = 1'b1; shift_busy = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (stat_o !== 16'h0 || err_irq !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%h/%b expected=0000/0", stat_o, err_irq);
    end
    @(negedge clk);
    rst = 1'b0; cmd_wr = 0; cmd_data = 0; hw_evt = 0; err_en = 0;
    err_irq_en = 0; shift_busy = 0;

    // R2 R3: each set bit alone
    for (int k = 0; k < 8; k++) step(1'b1, 16'h1 << setp[k], 6'h0, 5'h0, 1'b0, 1'b0, "R3");
    // R4: each clear bit alone
    for (int k = 0; k < 8; k++) step(1'b1, 16'h1 << clrp[k], 6'h0, 5'h0, 1'b0, 1'b0, "R4");
    // R5: set and clear together
    step(1'b1, 16'hAAAA, 6'h0, 5'h0, 1'b0, 1'b0, "R3");
    step(1'b1, 16'hFFFF, 6'h0, 5'h0, 1'b0, 1'b0, "R5");
    // R8: strobe low, and zero write
    step(1'b1, 16'hF0AA, 6'h0, 5'h0, 1'b0, 1'b0, "R3");
    step(1'b0, 16'hFFFF, 6'h0, 5'h0, 1'b0, 1'b0, "R8");
    step(1'b1, 16'h0000, 6'h0, 5'h0, 1'b0, 1'b0, "R8");
    step(1'b1, 16'h0F55, 6'h0, 5'h0, 1'b0, 1'b0, "R4");
    // R6: gated events with enables off, only mode fault lands
    step(1'b0, 16'h0, 6'h3f, 5'h00, 1'b0, 1'b0, "R6");
    step(1'b1, 16'h0040, 6'h0, 5'h00, 1'b0, 1'b0, "R4");
    for (int j = 1; j < 6; j++) begin
      step(1'b0, 16'h0, 6'h1 << j, 5'h1f ^ (5'h1 << (j-1)), 1'b0, 1'b0, "R6");
      step(1'b0, 16'h0, 6'h1 << j, 5'h1 << (j-1), 1'b0, 1'b0, "R6");
    end
    // R7: event together with clear of the same flag
    step(1'b1, 16'h0F50, 6'h3f, 5'h1f, 1'b0, 1'b0, "R7");
    step(1'b1, 16'h0F50, 6'h00, 5'h1f, 1'b0, 1'b0, "R4");
    // R9: interrupt enable and flag combinations
    step(1'b0, 16'h0, 6'h04, 5'h1f, 1'b1, 1'b0, "R9");
    idle(2, "R9");
    step(1'b0, 16'h0, 6'h0, 5'h1f, 1'b0, 1'b0, "R9");
    step(1'b1, 16'h0200, 6'h0, 5'h1f, 1'b1, 1'b0, "R9");
    idle(2, "R9");
    // R10: busy follows
    step(1'b0, 16'h0, 6'h0, 5'h0, 1'b0, 1'b1, "R10");
    step(1'b0, 16'h0, 6'h0, 5'h0, 1'b0, 1'b0, "R10");
    step(1'b0, 16'h0, 6'h0, 5'h0, 1'b0, 1'b1, "R10");
    // mixed patterns
    r = 32'h1BADF00D;
    for (int i = 0; i < 200; i++) begin
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      step(r[0], r[31:16] & {r[15:8], r[7:0]} , r[7:2], r[12:8], r[13], r[14], "R7 mixed");
    end
    step(1'b0, 16'h0, 6'h0, 5'h0, 1'b0, 1'b0, "R8");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule